// File: doc/BRIEF.md
# Parallel Test-Mode Compression Datapath

This block is the data path of a memory test mode. A one-bit-wide memory is built from four internal sectors, and each sector holds one quarter of the words. In normal operation the two most significant address bits pick one sector, and a read or a write touches only that sector. In test mode the sector-select bits are ignored. A write copies the input bit into the same location of all four sectors at once. A read gathers the four sector bits and reduces them to one result. When the four bits agree, the result is their shared value. When they disagree, the output is held at high impedance. Each access therefore covers four cells, so a full pattern runs in a quarter of the time.

The test mode is captured when an access cycle opens, and it holds for the rest of that cycle, page accesses included. For a tester there is also a pass/fail output. It compares each test-mode read against an expected bit and flags a mismatch or a high-impedance result.

Top module: `par_test_compress`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `dout_oe` and `fail_flag` are 0 and the latched test mode is off. Every cell of every sector reads back as 0.
- R2: In normal mode, a write stores `din` only in the sector numbered by `addr[ADDR_W-1 -: 2]`, at location `addr[ADDR_W-3:0]`. The other three sectors keep their contents.
- R3: In normal mode, a read (`acc_valid`=1, `acc_we`=0) drives `dout_oe`=1 in the next cycle, with `dout` equal to the selected sector's bit.
- R4: In test mode, a write stores `din` at location `addr[ADDR_W-3:0]` in all four sectors. The top two address bits have no effect.
- R5: In test mode, a read whose four sector bits are all equal gives `dout_oe`=1 and `dout` equal to that common value in the next cycle. The top two address bits have no effect.
- R6: In test mode, a read whose four sector bits are not all equal gives `dout_oe`=0 in the next cycle.
- R7: The test mode is taken from `tm_req` in a cycle where `cyc_start` is 1, and an access in that same cycle already uses the new value. Changes on `tm_req` while `cyc_start` is 0 have no effect.
- R8: In the cycle after a test-mode read, `fail_flag` is 1 exactly when `dout_oe` is 0 or `dout` differs from `exp_bit`. After any other kind of cycle, `fail_flag` is 0.
- R9: After a cycle with no read (a write or an idle cycle), `dout_oe` is 0 in the next cycle and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Marks the first cycle of an access cycle; captures the test mode |
| tm_req | input | 1 | Test-mode request, sampled when `cyc_start` is 1 |
| acc_valid | input | 1 | An access happens this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address; the top two bits select the sector |
| din | input | 1 | Write data |
| exp_bit | input | 1 | Expected bit for the test-mode comparison |
| dout | output | 1 | Read data, registered |
| dout_oe | output | 1 | Output enable; 0 means high impedance |
| fail_flag | output | 1 | Test-mode read failed (mismatch or high impedance) |

## Verification
On every cycle, the assertions check the following:
- outputs stay quiet after reset and after any cycle without a read;
- a normal-mode read always enables the output;
- a test-mode read either enables the output or raises the fail flag;
- `fail_flag` never rises outside a test-mode read;
- the latched mode changes only when a cycle starts.

Only the bench's scenarios can show whether the stored data is right. That covers the fan-out of test writes into all four sectors, the isolation of the sectors in normal writes, the exact merged value, and the high-impedance result when sectors disagree. Each of these needs a shadow of the array contents built up over many accesses.

// File: rtl/par_test_compress_pkg.sv
package par_test_compress_pkg;

    localparam int SEC_N = 4;
    localparam int SEL_W = $clog2(SEC_N);

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } acc_op_e;

    typedef struct packed {
        logic oe;
        logic val;
    } rd_res_t;

    // Reduce the sector bits to a common value, or to high impedance.
    function automatic rd_res_t merge_bits(input logic [SEC_N-1:0] bits);
        rd_res_t r;
        r.oe  = (&bits) | ~(|bits);
        r.val = r.oe & bits[0];
        return r;
    endfunction

    function automatic logic judge_fail(input rd_res_t r, input logic expect_v);
        return ~r.oe | (r.val ^ expect_v);
    endfunction

    function automatic acc_op_e decode_op(input logic vld, input logic we);
        if (!vld) return OP_IDLE;
        return we ? OP_WRITE : OP_READ;
    endfunction

endpackage

// File: rtl/tm_mode_latch.sv
module tm_mode_latch (
    input  logic clk,
    input  logic rst,
    input  logic cyc_start,
    input  logic tm_req,
    output logic mode_eff,
    output logic tm_q
);
    always_ff @(posedge clk) begin
        if (rst)
            tm_q <= 1'b0;
        else if (cyc_start)
            tm_q <= tm_req;
    end

    // Zero setup: an access in the opening cycle already sees the new mode.
    assign mode_eff = cyc_start ? tm_req : tm_q;
endmodule

// File: rtl/sector_array.sv
module sector_array
    import par_test_compress_pkg::*;
#(
    parameter int LOC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEC_N-1:0] wr_en,
    input  logic [LOC_W-1:0] loc,
    input  logic             din,
    output logic [SEC_N-1:0] rd_bits
);
    localparam int DEPTH = 1 << LOC_W;

    for (genvar s = 0; s < SEC_N; s++) begin : g_sec
        logic [DEPTH-1:0] cells;
        always_ff @(posedge clk) begin
            if (rst)
                cells <= '0;
            else if (wr_en[s])
                cells[loc] <= din;
        end
        assign rd_bits[s] = cells[loc];
    end
endmodule

// File: rtl/read_merge.sv
module read_merge
    import par_test_compress_pkg::*;
(
    input  logic [SEC_N-1:0] rd_bits,
    input  logic [SEL_W-1:0] sel,
    input  logic             test_mode,
    input  logic             expect_v,
    output rd_res_t          res,
    output logic             fail
);
    rd_res_t norm_res;
    rd_res_t test_res;

    always_comb begin
        norm_res.oe  = 1'b1;
        norm_res.val = rd_bits[sel];
        test_res     = merge_bits(rd_bits);
        res          = test_mode ? test_res : norm_res;
        fail         = test_mode & judge_fail(test_res, expect_v);
    end
endmodule

// File: rtl/par_test_compress.sv
module par_test_compress
    import par_test_compress_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_start,
    input  logic              tm_req,
    input  logic              acc_valid,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    input  logic              exp_bit,
    output logic              dout,
    output logic              dout_oe,
    output logic              fail_flag
);
    localparam int LOC_W = ADDR_W - SEL_W;

    logic             mode_eff;
    logic             tm_q;
    acc_op_e          op;
    logic [SEL_W-1:0] sel;
    logic [LOC_W-1:0] loc;
    logic [SEC_N-1:0] wr_en;
    logic [SEC_N-1:0] rd_bits;
    rd_res_t          res;
    logic             fail_c;

    assign op  = decode_op(acc_valid, acc_we);
    assign sel = addr[ADDR_W-1 -: SEL_W];
    assign loc = addr[LOC_W-1:0];

    tm_mode_latch u_mode (
        .clk       (clk),
        .rst       (rst),
        .cyc_start (cyc_start),
        .tm_req    (tm_req),
        .mode_eff  (mode_eff),
        .tm_q      (tm_q)
    );

    // Test writes fan out to every sector; normal writes go to one.
    always_comb begin
        for (int s = 0; s < SEC_N; s++)
            wr_en[s] = (op == OP_WRITE) && (mode_eff || sel == SEL_W'(s));
    end

    sector_array #(.LOC_W(LOC_W)) u_arr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .loc     (loc),
        .din     (din),
        .rd_bits (rd_bits)
    );

    read_merge u_merge (
        .rd_bits   (rd_bits),
        .sel       (sel),
        .test_mode (mode_eff),
        .expect_v  (exp_bit),
        .res       (res),
        .fail      (fail_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout      <= 1'b0;
            dout_oe   <= 1'b0;
            fail_flag <= 1'b0;
        end else begin
            dout      <= (op == OP_READ) && res.oe && res.val;
            dout_oe   <= (op == OP_READ) && res.oe;
            fail_flag <= (op == OP_READ) && fail_c;
        end
    end
endmodule

// File: rtl/par_test_compress_chk.sv
module par_test_compress_chk (
    input logic clk,
    input logic rst,
    input logic cyc_start,
    input logic acc_valid,
    input logic acc_we,
    input logic mode_eff,
    input logic tm_q,
    input logic dout_oe,
    input logic fail_flag
);
    logic rd;
    assign rd = acc_valid && !acc_we;

    // R1
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!dout_oe && !fail_flag && !tm_q));

    // R9
    assert_no_read_no_drive_R9: assert property (@(posedge clk) disable iff (rst)
        !rd |=> !dout_oe);

    // R3
    assert_normal_read_drives_R3: assert property (@(posedge clk) disable iff (rst)
        (rd && !mode_eff) |=> dout_oe);

    // R6
    assert_hiz_flags_fail_R6: assert property (@(posedge clk) disable iff (rst)
        (rd && mode_eff) |=> (dout_oe || fail_flag));

    // R8
    assert_fail_only_test_read_R8: assert property (@(posedge clk) disable iff (rst)
        !(rd && mode_eff) |=> !fail_flag);

    // R7
    assert_mode_held_R7: assert property (@(posedge clk) disable iff (rst)
        !cyc_start |=> $stable(tm_q));
endmodule

bind par_test_compress par_test_compress_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cyc_start (cyc_start),
    .acc_valid (acc_valid),
    .acc_we    (acc_we),
    .mode_eff  (mode_eff),
    .tm_q      (tm_q),
    .dout_oe   (dout_oe),
    .fail_flag (fail_flag)
);

// File: tb/par_test_compress_test.sv
`timescale 1ns/1ps
module par_test_compress_test;
    localparam int AW  = 6;
    localparam int LW  = AW - 2;
    localparam int DEP = 1 << LW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cyc_start = 1'b0, tm_req = 1'b0, acc_valid = 1'b0, acc_we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic din = 1'b0, exp_bit = 1'b0;
    logic dout, dout_oe, fail_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit mem_m [4][DEP];
    bit mode_m = 0;

    always #2 clk = ~clk;

    par_test_compress #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .tm_req(tm_req),
        .acc_valid(acc_valid), .acc_we(acc_we), .addr(addr), .din(din),
        .exp_bit(exp_bit), .dout(dout), .dout_oe(dout_oe), .fail_flag(fail_flag)
    );

    task automatic chk(input string req, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, expv);
        end
    endtask

    // Bench-side expected merge: returns {oe, val}.
    function automatic logic [1:0] exp_merge(input int l);
        int ones = 0;
        for (int s = 0; s < 4; s++) ones += mem_m[s][l];
        if (ones == 4) return 2'b11;
        if (ones == 0) return 2'b10;
        return 2'b00;
    endfunction

    // One access: drive at a falling edge, check at the next falling edge.
    task automatic op(input bit st, input bit tm, input bit v, input bit we,
                      input logic [AW-1:0] a, input bit d, input bit e, input string req);
        bit eff;
        int sec, l;
        logic [1:0] r;
        logic e_oe, e_val, e_fail;
        @(negedge clk);
        cyc_start = st; tm_req = tm; acc_valid = v; acc_we = we;
        addr = a; din = d; exp_bit = e;
        eff = st ? tm : mode_m;
        if (st) mode_m = tm;
        sec = int'(a[AW-1 -: 2]);
        l = int'(a[LW-1:0]);
        e_oe = 0; e_val = 0; e_fail = 0;
        if (v && !we) begin
            if (eff) begin
                r = exp_merge(l);
                e_oe = r[1]; e_val = r[0];
                e_fail = !e_oe || (e_val != e);
            end else begin
                e_oe = 1; e_val = mem_m[sec][l];
            end
        end
        if (v && we) begin
            for (int s = 0; s < 4; s++)
                if (eff || s == sec) mem_m[s][l] = d;
        end
        @(negedge clk);
        chk({req, " oe"}, dout_oe, e_oe);
        chk({req, " dout"}, dout, e_val);
        chk({req, " fail"}, fail_flag, e_fail);
        cyc_start = 0; acc_valid = 0;
    endtask

    function automatic logic [AW-1:0] mk(input int s, input int l);
        return {2'(s), LW'(l)};
    endfunction

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk("R1 reset oe", dout_oe, 1'b0);
        chk("R1 reset fail", fail_flag, 1'b0);
        @(negedge clk); rst = 0;
        chk("R1 post-reset oe", dout_oe, 1'b0);

        // R1: cleared array, normal reads of every sector
        for (int s = 0; s < 4; s++) op(1, 0, 1, 0, mk(s, 5), 0, 0, "R1 cleared");
        // R7: test mode off after reset, a test-style read must not flag
        op(0, 1, 1, 0, mk(0, 0), 0, 1, "R7 tm ignored w/o start");

        // R2 / R3: normal write to one sector, others untouched
        op(1, 0, 1, 1, mk(2, 3), 1, 0, "R2 normal write");
        for (int s = 0; s < 4; s++) op(0, 1, 1, 0, mk(s, 3), 0, 0, "R2 R3 isolation");
        // R6: sectors disagree -> high impedance and fail
        op(1, 1, 1, 0, mk(0, 3), 0, 1, "R6 hiz");
        // R4: test write fans out, top bits ignored
        op(0, 0, 1, 1, mk(1, 3), 1, 0, "R4 test write");
        op(0, 0, 1, 0, mk(3, 3), 0, 1, "R5 common one pass");
        op(0, 0, 1, 0, mk(2, 3), 0, 0, "R5 R8 mismatch fail");
        op(1, 0, 1, 0, mk(0, 3), 0, 0, "R4 sector0 check");
        op(0, 1, 1, 0, mk(1, 3), 0, 0, "R4 sector1 check");
        // R9: write then idle
        op(0, 0, 1, 1, mk(0, 7), 1, 0, "R9 write quiet");
        op(0, 0, 0, 0, mk(0, 7), 0, 0, "R9 idle quiet");
        // R7: start and access in the same cycle with a new mode
        op(1, 1, 1, 1, mk(2, 9), 1, 0, "R7 same-cycle write");
        op(1, 0, 1, 0, mk(3, 9), 0, 0, "R7 R4 fanout seen");
        op(1, 1, 1, 0, mk(1, 7), 0, 0, "R6 R8 partial");
        op(0, 0, 1, 0, mk(0, 10), 0, 0, "R5 common zero");

        // Constrained random traffic
        for (int i = 0; i < 600; i++) begin
            bit st = ($urandom_range(0, 7) == 0);
            op(st, 1'($urandom), ($urandom_range(0, 5) != 0), 1'($urandom),
               AW'($urandom), 1'($urandom), 1'($urandom),
               "R2 R3 R4 R5 R6 R8 R9 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule